// File: doc/BRIEF.md
# Shared-Address Read/Write Memory Port with Configurable Collision Semantics

This block is a single memory port in which one address serves both a synchronous write and a synchronous read. The read result is held in an output register. The word is split into byte lanes. A write updates only the lanes it enables. The enable is either one main write strobe combined with per-lane enables, or that strobe alone.

A clock enable gates both reading and writing. A read enable gates only reading. Each of these enables can be removed by a parameter; when removed, its input is ignored.

The value captured into the read register when the port reads and writes the same word in the same cycle is chosen at elaboration by a mode parameter. There are five choices:
- hold the register;
- return the previous word;
- return the word as it stands after the write;
- guarantee only the written lanes;
- guarantee only the unwritten lanes.

Top module: `rwp_port`

## Requirements
- R1: With clock enable and read enable high and no write, `rd_data` shows the stored word at `addr` after exactly one rising edge.
- R2: With separate lane enables (`SEP_BE`=1), lane i (bits 8i+7..8i with the default 8-bit lane) is written only when the clock enable (if present), `wr_en` and `wr_be[i]` are all 1. Other lanes keep their contents.
- R3: With `SEP_BE`=0, `wr_en` writes the whole word and `wr_be` has no effect on the memory.
- R4: With `HAS_CLKEN`=1 and `clk_en` low, nothing is written and `rd_data` keeps its value.
- R5: With `HAS_RDEN`=1 and `rd_en` low, `rd_data` keeps its value while a requested write still takes place.
- R6: With `HAS_CLKEN`=0 and `HAS_RDEN`=0, the `clk_en` and `rd_en` inputs are ignored and behave as if held high.
- R7: Mode hold (`MODE`=1): in a cycle with the clock enable and `wr_en` high, no read happens and `rd_data` is unchanged, even when every `wr_be` bit is 0.
- R8: Mode old (`MODE`=2): on a collision, every bit of `rd_data` returns the word as stored before the write.
- R9: Mode new (`MODE`=3): on a collision, every bit of `rd_data` returns the word as stored after the write. Written lanes show `wr_data`; the other lanes show their stored bits.
- R10: Mode new-only (`MODE`=4): on a collision, the written lanes of `rd_data` equal `wr_data`, and the other bits are unspecified.
- R11: Mode unspecified (`MODE`=0): on a collision, the unwritten lanes of `rd_data` return the stored bits, and the written lanes are unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| addr | input | AW | Shared word address for read and write |
| wr_data | input | DW | Data to be written |
| wr_en | input | 1 | Main write strobe |
| wr_be | input | NB | Per-lane write enables (used when SEP_BE=1) |
| clk_en | input | 1 | Gates reading and writing (used when HAS_CLKEN=1) |
| rd_en | input | 1 | Gates reading only (used when HAS_RDEN=1) |
| rd_data | output | DW | Registered read result |

## Verification
The same stimulus drives one instance per collision mode plus one instance without enables and with whole-word writes. Any difference between instances is therefore due to the mode or the configuration.

Plain reads after a fill pass establish the one-cycle latency. Partial-lane collisions are then applied, and they separate the modes:
- a half-lane mask splits new from old;
- it shows which lanes new-only and unspecified still guarantee.

A write with the strobe high and no lanes enabled separates the hold mode from the others. Cycles with only the clock enable or only the read enable dropped show which enable blocks the write. A burst of random operations on four addresses mixes all of these cases back to back.

// File: rtl/rwp_pkg.sv
package rwp_pkg;

   // Read-during-write behaviour of the shared-address port.
   typedef enum logic [2:0] {
      RW_UNDEF   = 3'd0,
      RW_NOCHG   = 3'd1,
      RW_OLD     = 3'd2,
      RW_NEW     = 3'd3,
      RW_NEWONLY = 3'd4
   } rdwr_e;

   // Number of write lanes: a lane wider than the word covers the whole word.
   function automatic int lane_count(input int dw, input int bw);
      return (bw >= dw) ? 1 : dw / bw;
   endfunction

   function automatic int lane_width(input int dw, input int bw);
      return (bw >= dw) ? dw : bw;
   endfunction

endpackage

// File: rtl/rwp_gate.sv
module rwp_gate #(
   parameter int DW        = 32,
   parameter int NB        = 4,
   parameter int LW        = 8,
   parameter bit SEP_BE    = 1'b1,
   parameter bit HAS_CLKEN = 1'b1,
   parameter bit HAS_RDEN  = 1'b1
) (
   input  logic          clk_en,
   input  logic          rd_en,
   input  logic          wr_en,
   input  logic [NB-1:0] wr_be,
   output logic          ce_eff,
   output logic          rd_go,
   output logic          wr_go,
   output logic [NB-1:0] lane_we,
   output logic [DW-1:0] bit_mask
);

   logic re_eff;

   if (HAS_CLKEN) begin : g_ce
      assign ce_eff = clk_en;
   end else begin : g_no_ce
      assign ce_eff = 1'b1;
   end

   if (HAS_RDEN) begin : g_re
      assign re_eff = rd_en;
   end else begin : g_no_re
      assign re_eff = 1'b1;
   end

   assign rd_go = ce_eff & re_eff;
   assign wr_go = ce_eff & wr_en;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      if (SEP_BE) begin : g_sep
         assign lane_we[i] = wr_go & wr_be[i];
      end else begin : g_whole
         assign lane_we[i] = wr_go;
      end
      assign bit_mask[i*LW +: LW] = {LW{lane_we[i]}};
   end

endmodule

// File: rtl/rwp_store.sv
module rwp_store #(
   parameter int AW = 6,
   parameter int DW = 32,
   parameter int NB = 4,
   parameter int LW = 8,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wr_data,
   input  logic [NB-1:0] lane_we,
   output logic [DW-1:0] old_word
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int i = 0; i < NB; i++) begin
         if (lane_we[i]) begin
            mem[addr][i*LW +: LW] <= wr_data[i*LW +: LW];
         end
      end
   end

   // Pre-write contents of the addressed word, sampled by the read register.
   assign old_word = mem[addr];

endmodule

// File: rtl/rwp_rdsel.sv
module rwp_rdsel #(
   parameter int             DW   = 32,
   parameter rwp_pkg::rdwr_e MODE = rwp_pkg::RW_OLD
) (
   input  logic          clk,
   input  logic          rd_go,
   input  logic          wr_go,
   input  logic [DW-1:0] bit_mask,
   input  logic [DW-1:0] old_word,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data
);

   logic          load;
   logic [DW-1:0] next_q;
   logic [DW-1:0] rd_q;

   if (MODE == rwp_pkg::RW_NOCHG) begin : g_nochg
      assign load   = rd_go & ~wr_go;
      assign next_q = old_word;
   end else if (MODE == rwp_pkg::RW_NEW || MODE == rwp_pkg::RW_NEWONLY) begin : g_new
      // Unspecified bits of new-only take the stored value: same datapath as new.
      assign load   = rd_go;
      assign next_q = (old_word & ~bit_mask) | (wr_data & bit_mask);
   end else begin : g_old
      // Old and unspecified share the pre-write word.
      assign load   = rd_go;
      assign next_q = old_word;
   end

   always_ff @(posedge clk) begin
      if (load) begin
         rd_q <= next_q;
      end
   end

   assign rd_data = rd_q;

endmodule

// File: rtl/rwp_port.sv
module rwp_port #(
   parameter int             AW        = 6,
   parameter int             DW        = 32,
   parameter int             BYTE      = 8,
   parameter rwp_pkg::rdwr_e MODE      = rwp_pkg::RW_OLD,
   parameter bit             SEP_BE    = 1'b1,
   parameter bit             HAS_CLKEN = 1'b1,
   parameter bit             HAS_RDEN  = 1'b1,
   localparam int            NB        = rwp_pkg::lane_count(DW, BYTE),
   localparam int            LW        = rwp_pkg::lane_width(DW, BYTE)
) (
   input  logic          clk,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_en,
   input  logic [NB-1:0] wr_be,
   input  logic          clk_en,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data
);

   import rwp_pkg::*;

   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("rwp_port: AW out of range");
   end
   if (DW < 1) begin : g_bad_dw
      $error("rwp_port: DW must be positive");
   end
   if (BYTE < DW && (DW % BYTE) != 0) begin : g_bad_lane
      $error("rwp_port: DW must be a multiple of BYTE");
   end

   logic          ce_eff;
   logic          rd_go;
   logic          wr_go;
   logic [NB-1:0] lane_we;
   logic [DW-1:0] bit_mask;
   logic [DW-1:0] old_word;

   rwp_gate #(
      .DW(DW), .NB(NB), .LW(LW),
      .SEP_BE(SEP_BE), .HAS_CLKEN(HAS_CLKEN), .HAS_RDEN(HAS_RDEN)
   ) u_gate (
      .clk_en  (clk_en),
      .rd_en   (rd_en),
      .wr_en   (wr_en),
      .wr_be   (wr_be),
      .ce_eff  (ce_eff),
      .rd_go   (rd_go),
      .wr_go   (wr_go),
      .lane_we (lane_we),
      .bit_mask(bit_mask)
   );

   rwp_store #(.AW(AW), .DW(DW), .NB(NB), .LW(LW)) u_store (
      .clk     (clk),
      .addr    (addr),
      .wr_data (wr_data),
      .lane_we (lane_we),
      .old_word(old_word)
   );

   rwp_rdsel #(.DW(DW), .MODE(MODE)) u_rdsel (
      .clk     (clk),
      .rd_go   (rd_go),
      .wr_go   (wr_go),
      .bit_mask(bit_mask),
      .old_word(old_word),
      .wr_data (wr_data),
      .rd_data (rd_data)
   );

   // ---------------- assertions ----------------
   logic past_v = 1'b0;
   always_ff @(posedge clk) past_v <= 1'b1;

   assert_lane_gate_R2: assert property (@(posedge clk) disable iff (!past_v)
      (|lane_we) |-> (wr_en && (!HAS_CLKEN || clk_en)));

   if (HAS_CLKEN) begin : g_a_ce
      assert_ce_hold_R4: assert property (@(posedge clk) disable iff (!past_v)
         !clk_en |=> $stable(rd_data));
   end
   if (HAS_RDEN) begin : g_a_re
      assert_re_hold_R5: assert property (@(posedge clk) disable iff (!past_v)
         !rd_en |=> $stable(rd_data));
   end

   if (MODE == RW_NOCHG) begin : g_a_nochg
      assert_nochg_hold_R7: assert property (@(posedge clk) disable iff (!past_v)
         (ce_eff && wr_en) |=> $stable(rd_data));
   end
   if (MODE == RW_OLD) begin : g_a_old
      assert_old_word_R8: assert property (@(posedge clk) disable iff (!past_v)
         rd_go |=> rd_data == $past(old_word));
   end
   if (MODE == RW_NEW) begin : g_a_new
      assert_new_full_R9: assert property (@(posedge clk) disable iff (!past_v)
         (rd_go && (&lane_we)) |=> rd_data == $past(wr_data));
   end
   if (MODE == RW_NEW || MODE == RW_NEWONLY) begin : g_a_newonly
      assert_new_lanes_R10: assert property (@(posedge clk) disable iff (!past_v)
         rd_go |=> ((rd_data ^ $past(wr_data)) & $past(bit_mask)) == '0);
   end
   if (MODE == RW_UNDEF || MODE == RW_NEW) begin : g_a_keep
      assert_unwritten_lanes_R11: assert property (@(posedge clk) disable iff (!past_v)
         rd_go |=> ((rd_data ^ $past(old_word)) & ~$past(bit_mask)) == '0);
   end

endmodule

// File: tb/sim_rwp_port.sv
`timescale 1ns/1ps
module sim_rwp_port;

   localparam int AW = 6;
   localparam int DW = 32;
   localparam int NB = 4;
   localparam int NM = 5;   // one instance per collision mode
   localparam int NI = 6;   // plus the enable-less, whole-word instance

   logic          clk = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_en = 1'b0;
   logic [NB-1:0] wr_be = '0;
   logic          clk_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] rd_m [NM];
   logic [DW-1:0] rd_c;

   always #4 clk = ~clk;   // 125 MHz

   for (genvar k = 0; k < NM; k++) begin : g_m
      rwp_port #(.AW(AW), .DW(DW), .BYTE(8), .MODE(rwp_pkg::rdwr_e'(k)),
                 .SEP_BE(1'b1), .HAS_CLKEN(1'b1), .HAS_RDEN(1'b1)) u0 (
         .clk(clk), .addr(addr), .wr_data(wr_data), .wr_en(wr_en), .wr_be(wr_be),
         .clk_en(clk_en), .rd_en(rd_en), .rd_data(rd_m[k]));
   end

   // R3 and R6 instance: whole-word writes, no clock enable, no read enable.
   if (1) begin : g_c
      rwp_port #(.AW(AW), .DW(DW), .BYTE(8), .MODE(rwp_pkg::RW_OLD),
                 .SEP_BE(1'b0), .HAS_CLKEN(1'b0), .HAS_RDEN(1'b0)) u0 (
         .clk(clk), .addr(addr), .wr_data(wr_data), .wr_en(wr_en), .wr_be(wr_be),
         .clk_en(clk_en), .rd_en(rd_en), .rd_data(rd_c));
   end

   typedef struct packed {
      logic [NI-1:0][DW-1:0] exp;
      logic [NI-1:0][DW-1:0] care;
      logic [23:0]           tag;
   } item_t;

   item_t q[$];
   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 1'b0;

   // Reference model state.
   logic [DW-1:0] mem_s [1 << AW];
   logic          val_s [1 << AW];
   logic [DW-1:0] mem_c [1 << AW];
   logic          val_c [1 << AW];
   logic [DW-1:0] hold_e [NI];
   logic [DW-1:0] hold_k [NI];

   // Per-instance requirement tags: modes 0..4, then the whole-word instance.
   logic [47:0] inst_tag [NI];
   initial begin
      inst_tag[0] = "R11   ";
      inst_tag[1] = "R7    ";
      inst_tag[2] = "R8    ";
      inst_tag[3] = "R9    ";
      inst_tag[4] = "R10   ";
      inst_tag[5] = "R3 R6 ";
      for (int i = 0; i < (1 << AW); i++) begin
         val_s[i] = 1'b0;
         val_c[i] = 1'b0;
      end
      for (int k = 0; k < NI; k++) begin
         hold_e[k] = '0;
         hold_k[k] = '0;
      end
   end

   function automatic logic [DW-1:0] lanes(input logic [NB-1:0] be);
      logic [DW-1:0] m;
      for (int i = 0; i < NB; i++) m[i*8 +: 8] = {8{be[i]}};
      return m;
   endfunction

   task automatic op(input logic ce, input logic we, input logic re,
                     input logic [NB-1:0] be, input int a, input logic [DW-1:0] d,
                     input logic [23:0] tag);
      item_t         it;
      logic [DW-1:0] m;
      logic [DW-1:0] old;
      logic [DW-1:0] okc;
      @(negedge clk);
      clk_en = ce; wr_en = we; rd_en = re; wr_be = be;
      addr = AW'(a); wr_data = d;
      // Lane-gated instances (R2, R4, R5).
      m   = (ce && we) ? lanes(be) : '0;
      old = mem_s[a];
      okc = val_s[a] ? '1 : '0;
      if (ce && re && !(we && (rwp_pkg::rdwr_e'(1) == rwp_pkg::RW_NOCHG))) begin end
      for (int k = 0; k < NM; k++) begin
         if (ce && re && !(k == 1 && we)) begin
            case (k)
               0: begin hold_e[k] = old;                      hold_k[k] = okc & ~m; end
               3: begin hold_e[k] = (old & ~m) | (d & m);     hold_k[k] = (okc & ~m) | m; end
               4: begin hold_e[k] = d & m;                    hold_k[k] = m; end
               default: begin hold_e[k] = old;                hold_k[k] = okc; end
            endcase
         end
      end
      mem_s[a] = (old & ~m) | (d & m);
      if (m == '1) val_s[a] = 1'b1;
      // Whole-word instance: always enabled, wr_be ignored (R3, R6).
      hold_e[5] = mem_c[a];
      hold_k[5] = val_c[a] ? '1 : '0;
      if (we) begin
         mem_c[a] = d;
         val_c[a] = 1'b1;
      end
      for (int k = 0; k < NI; k++) begin
         it.exp[k]  = hold_e[k];
         it.care[k] = hold_k[k];
      end
      it.tag = tag;
      q.push_back(it);
   endtask

   // Monitor: pops one expectation per edge, samples 2 ns after the edge.
   initial begin
      forever begin
         item_t         it;
         logic [DW-1:0] got;
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            it = q.pop_front();
            for (int k = 0; k < NI; k++) begin
               got = (k < NM) ? rd_m[k] : rd_c;
               if (it.care[k] != '0) begin
                  n_checks++;
                  if (((got ^ it.exp[k]) & it.care[k]) != '0) begin
                     n_errors++;
                     $display("FAIL %s inst %s got %h expected %h mask %h",
                              it.tag, inst_tag[k], got, it.exp[k], it.care[k]);
                  end
               end
            end
         end
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_errors++;
         $display("FAIL R1 watchdog expired got 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      // Fill every word, reads disabled (R2 whole-lane writes).
      for (int a = 0; a < (1 << AW); a++)
         op(1, 1, 0, 4'hF, a, {8'(a), 8'hA5, 8'(a * 3), 8'h5A}, "R2 ");
      // Plain reads: one-cycle latency (R1).
      op(1, 0, 1, 4'h0, 5, '0, "R1 ");
      op(1, 0, 1, 4'h0, 6, '0, "R1 ");
      op(1, 0, 1, 4'h0, 63, '0, "R1 ");
      // Partial-lane collision: separates the five modes.
      op(1, 1, 1, 4'b0101, 5, 32'h1122_3344, "R2 ");
      op(1, 0, 1, 4'h0, 5, '0, "R2 ");
      // Strobe high, no lanes: no write, hold mode still holds (R7).
      op(1, 1, 1, 4'b0000, 6, 32'hDEAD_BEEF, "R7 ");
      op(1, 0, 1, 4'h0, 6, '0, "R2 ");
      // Clock enable low: no write, no read (R4).
      op(1, 0, 1, 4'h0, 7, '0, "R1 ");
      op(0, 1, 1, 4'hF, 7, 32'hCAFE_F00D, "R4 ");
      op(0, 0, 1, 4'h0, 8, '0, "R4 ");
      op(1, 0, 1, 4'h0, 7, '0, "R4 ");
      // Read enable low: write happens, output held (R5).
      op(1, 1, 0, 4'hF, 8, 32'h0BAD_F00D, "R5 ");
      op(1, 0, 0, 4'h0, 9, '0, "R5 ");
      op(1, 0, 1, 4'h0, 8, '0, "R5 ");
      // Full-word collision (R9, R8) and back-to-back on one word (R10, R11).
      op(1, 1, 1, 4'hF, 9, 32'h1234_5678, "R9 ");
      op(1, 1, 1, 4'b1000, 9, 32'hFF00_00FF, "R10");
      op(1, 1, 1, 4'b0010, 9, 32'h00AB_CD00, "R11");
      op(1, 0, 1, 4'h0, 9, '0, "R8 ");
      // Mixed random traffic on four words.
      for (int i = 0; i < 200; i++)
         op(($urandom % 8) != 0, ($urandom % 2) == 1, ($urandom % 4) != 0,
            NB'($urandom), int'($urandom % 4), $urandom, "R2 ");
      op(1, 0, 1, 4'h0, 0, '0, "R1 ");
      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule